// File: doc/BRIEF.md
# Storage-to-DMA Sideband Marker Controller

This block sits beside a storage-card peripheral and a pipe-based DMA engine. It does not move data. It counts the bytes that cross the boundary and tells the DMA engine where blocks and transactions end. Software sets it up over a simple 32-bit register bus. The settings are a configuration word, two logical pipe sizes, two pipe identifiers, a block size and a transaction size. Software then starts one of two state machines by writing to a command offset.

The producer direction carries data from the peripheral to memory. Here the block watches a valid/byte-count beat stream. Each time the bytes of the current block reach the programmed block size, it raises a one-cycle block-end marker. When the bytes of the whole transaction reach the programmed transaction size, and transaction-end signalling is enabled, it raises a one-cycle transaction-end marker and goes idle. The consumer direction carries data from memory to the peripheral. It counts consumer beats up to the consumer pipe size, or runs without end when the endless-transfer bit is set.

Live producer counters can be read back at any time. Both machines report idle through a status word and through two output pins. A bypass bit silences all markers and makes both machines report idle. A write to the soft-reset offset returns every register and every counter to its reset value.

Top module: `dma_sideband_ctrl`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0x00010001 (bit 0 producer idle, bit 16 consumer idle), the configuration word reads 0, and both marker outputs are low.
- R2: The configuration word at 0x00 keeps only bits 1:0 (producer request select), 3:2 (consumer request select), 4 (transaction-end enable), 16 (bypass), 17 (direct) and 18 (endless consumer). Writing all ones reads back 0x0007001F. The pipe-ID word at 0x1C keeps bits 4:0 and 20:16 (0x001F001F). The four size words (producer pipe 0x14, consumer pipe 0x18, block 0x24, transaction 0x28) keep all 32 bits.
- R3: A write to 0x0C clears the producer counters and makes the producer busy (status bit 0 low) from the next cycle. It changes no readable register.
- R4: While the producer is busy, each beat adds its byte count to both counters. Offset 0x20 reads the block counter in bits 15:0 and the transaction counter in bits 31:16.
- R5: A beat that brings the block counter to or past the low 16 bits of the block size produces a block-end pulse in the next cycle and returns the block counter to zero.
- R6: With configuration bit 4 set, a beat that brings the transaction counter to or past the transaction size produces a transaction-end pulse in the next cycle. The producer then goes idle with both counters at zero. When the same beat also ends a block, both pulses fire in the same cycle.
- R7: With configuration bit 4 clear, no transaction-end pulse is produced. The producer stays busy and the transaction counter keeps counting.
- R8: A write to 0x10 makes the consumer busy (status bit 16 low). The consumer returns to idle once its beats reach the consumer pipe size, unless configuration bit 18 is set, in which case it stays busy.
- R9: While configuration bit 16 (bypass) is set, no marker pulses appear and both machines report idle.
- R10: Any write to 0x08 returns every register, counter and state machine to its reset value.
- R11: Writes to undefined offsets change nothing. Reads of undefined offsets (for example 0x2C and 0x40) return 0.
- R12: Producer beats that arrive while the producer is idle are ignored: the counters stay zero and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| prod_valid | input | 1 | Producer beat valid |
| prod_bytes | input | BEAT_W | Bytes carried by the producer beat |
| cons_valid | input | 1 | Consumer beat valid |
| cons_bytes | input | BEAT_W | Bytes carried by the consumer beat |
| blk_end_o | output | 1 | Block-end marker pulse |
| txn_end_o | output | 1 | Transaction-end marker pulse |
| prod_idle_o | output | 1 | Producer idle |
| cons_idle_o | output | 1 | Consumer idle |

## Verification
The hardest case to reach is a single beat that ends a block and the whole transaction at once. A separate case is a transaction end with a partial block still open. The first requires the block size to divide the transaction size, with beats that land exactly on both limits. The stimulus programs an 8-byte block and a 24-byte transaction, then sends 4-byte beats, so the sixth beat closes both. A second run with a 20-byte transaction closes the transaction while the block counter sits mid-block. That run shows the transaction marker firing on its own and the block counter being cleared without a block marker.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  // Counter width is fixed by the tracker word layout (two 16-bit halves).
  localparam int CNT_W = 16;

  localparam logic [7:0] OFS_CFG    = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_SRST   = 8'h08;
  localparam logic [7:0] OFS_PSTART = 8'h0C;
  localparam logic [7:0] OFS_CSTART = 8'h10;
  localparam logic [7:0] OFS_PPIPE  = 8'h14;
  localparam logic [7:0] OFS_CPIPE  = 8'h18;
  localparam logic [7:0] OFS_PID    = 8'h1C;
  localparam logic [7:0] OFS_TRK    = 8'h20;
  localparam logic [7:0] OFS_BLK    = 8'h24;
  localparam logic [7:0] OFS_TXN    = 8'h28;

  localparam int NUM_SIZE = 4;
  localparam int SZ_PPIPE = 0;
  localparam int SZ_CPIPE = 1;
  localparam int SZ_BLK   = 2;
  localparam int SZ_TXN   = 3;

  typedef struct packed {
    logic       endless;
    logic       direct;
    logic       bypass;
    logic       txn_en;
    logic [1:0] cons_sel;
    logic [1:0] prod_sel;
  } cfg_t;

  function automatic logic [7:0] size_ofs(input int idx);
    case (idx)
      SZ_PPIPE: size_ofs = OFS_PPIPE;
      SZ_CPIPE: size_ofs = OFS_CPIPE;
      SZ_BLK:   size_ofs = OFS_BLK;
      default:  size_ofs = OFS_TXN;
    endcase
  endfunction

  function automatic cfg_t cfg_from_word(input logic [31:0] w);
    cfg_t c;
    c.prod_sel = w[1:0];
    c.cons_sel = w[3:2];
    c.txn_en   = w[4];
    c.bypass   = w[16];
    c.direct   = w[17];
    c.endless  = w[18];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input cfg_t c);
    return {13'd0, c.endless, c.direct, c.bypass, 11'd0, c.txn_en, c.cons_sel, c.prod_sel};
  endfunction

  // True when adding 'add' to 'cnt' reaches or passes 'limit'.
  function automatic logic reaches(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] add,
                                   input logic [CNT_W-1:0] limit);
    logic [CNT_W:0] sum;
    sum = {1'b0, cnt} + {1'b0, add};
    return sum >= {1'b0, limit};
  endfunction

endpackage

// File: rtl/dsc_regs.sv
module dsc_regs
  import dsc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             prod_idle,
  input  logic             cons_idle,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic [CNT_W-1:0] txn_cnt,
  output cfg_t             cfg,
  output logic [31:0]      size_q [NUM_SIZE],
  output logic             soft_rst,
  output logic             prod_start,
  output logic             cons_start
);

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  logic [4:0] pid_prod_q;
  logic [4:0] pid_cons_q;

  assign soft_rst   = bus_wr && hit(bus_addr, OFS_SRST);
  assign prod_start = bus_wr && hit(bus_addr, OFS_PSTART);
  assign cons_start = bus_wr && hit(bus_addr, OFS_CSTART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (soft_rst) begin
      cfg <= '0;
    end else if (bus_wr && hit(bus_addr, OFS_CFG)) begin
      cfg <= cfg_from_word(bus_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_prod_q <= '0;
      pid_cons_q <= '0;
    end else if (soft_rst) begin
      pid_prod_q <= '0;
      pid_cons_q <= '0;
    end else if (bus_wr && hit(bus_addr, OFS_PID)) begin
      pid_prod_q <= bus_wdata[4:0];
      pid_cons_q <= bus_wdata[20:16];
    end
  end

  for (genvar i = 0; i < NUM_SIZE; i++) begin : g_size
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q[i] <= '0;
      end else if (soft_rst) begin
        size_q[i] <= '0;
      end else if (bus_wr && hit(bus_addr, size_ofs(i))) begin
        size_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFS_CFG))   bus_rdata = cfg_to_word(cfg);
    if (hit(bus_addr, OFS_STAT))  bus_rdata = {15'd0, cons_idle, 15'd0, prod_idle};
    if (hit(bus_addr, OFS_PID))   bus_rdata = {11'd0, pid_cons_q, 11'd0, pid_prod_q};
    if (hit(bus_addr, OFS_TRK))   bus_rdata = {txn_cnt, blk_cnt};
    if (hit(bus_addr, OFS_PPIPE)) bus_rdata = size_q[SZ_PPIPE];
    if (hit(bus_addr, OFS_CPIPE)) bus_rdata = size_q[SZ_CPIPE];
    if (hit(bus_addr, OFS_BLK))   bus_rdata = size_q[SZ_BLK];
    if (hit(bus_addr, OFS_TXN))   bus_rdata = size_q[SZ_TXN];
  end

endmodule

// File: rtl/dsc_producer.sv
module dsc_producer
  import dsc_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              start,
  input  logic              valid,
  input  logic [BEAT_W-1:0] bytes,
  input  logic [CNT_W-1:0]  blk_size,
  input  logic [CNT_W-1:0]  txn_size,
  input  logic              txn_en,
  input  logic              bypass,
  output logic              busy,
  output logic [CNT_W-1:0]  blk_cnt,
  output logic [CNT_W-1:0]  txn_cnt,
  output logic              blk_hit,
  output logic              txn_hit,
  output logic              blk_end,
  output logic              txn_end
);

  logic             active;
  logic [CNT_W-1:0] add;

  assign active  = busy && valid;
  assign add     = CNT_W'(bytes);
  assign blk_hit = active && reaches(blk_cnt, add, blk_size);
  assign txn_hit = active && txn_en && reaches(txn_cnt, add, txn_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      blk_cnt <= '0;
      txn_cnt <= '0;
    end else if (soft_rst) begin
      busy    <= 1'b0;
      blk_cnt <= '0;
      txn_cnt <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      blk_cnt <= '0;
      txn_cnt <= '0;
    end else if (txn_hit) begin
      busy    <= 1'b0;
      blk_cnt <= '0;
      txn_cnt <= '0;
    end else if (active) begin
      blk_cnt <= blk_hit ? '0 : blk_cnt + add;
      txn_cnt <= txn_cnt + add;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_end <= 1'b0;
      txn_end <= 1'b0;
    end else if (soft_rst || start) begin
      blk_end <= 1'b0;
      txn_end <= 1'b0;
    end else begin
      blk_end <= blk_hit && !bypass;
      txn_end <= txn_hit && !bypass;
    end
  end

endmodule

// File: rtl/dsc_consumer.sv
module dsc_consumer
  import dsc_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              start,
  input  logic              valid,
  input  logic [BEAT_W-1:0] bytes,
  input  logic [CNT_W-1:0]  pipe_size,
  input  logic              endless,
  output logic              busy,
  output logic              done_hit
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] add;
  logic             active;

  assign add      = CNT_W'(bytes);
  assign active   = busy && valid;
  assign done_hit = active && !endless && reaches(cnt, add, pipe_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (soft_rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done_hit) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (active) begin
      cnt  <= cnt + add;
    end
  end

endmodule

// File: rtl/dma_sideband_ctrl.sv
module dma_sideband_ctrl
  import dsc_pkg::*;
#(
  parameter int AW     = 8,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              prod_valid,
  input  logic [BEAT_W-1:0] prod_bytes,
  input  logic              cons_valid,
  input  logic [BEAT_W-1:0] cons_bytes,
  output logic              blk_end_o,
  output logic              txn_end_o,
  output logic              prod_idle_o,
  output logic              cons_idle_o
);

  cfg_t             cfg;
  logic [31:0]      size_q [NUM_SIZE];
  logic             soft_rst;
  logic             prod_start;
  logic             cons_start;
  logic             prod_busy;
  logic             cons_busy;
  logic             cons_done;
  logic [CNT_W-1:0] blk_cnt;
  logic [CNT_W-1:0] txn_cnt;
  logic             blk_hit;
  logic             txn_hit;
  logic             cfg_bypass;
  logic             cfg_txn_en;

  assign cfg_bypass  = cfg.bypass;
  assign cfg_txn_en  = cfg.txn_en;
  assign prod_idle_o = !prod_busy || cfg_bypass;
  assign cons_idle_o = !cons_busy || cfg_bypass;

  dsc_regs #(.AW(AW)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .prod_idle  (prod_idle_o),
    .cons_idle  (cons_idle_o),
    .blk_cnt    (blk_cnt),
    .txn_cnt    (txn_cnt),
    .cfg        (cfg),
    .size_q     (size_q),
    .soft_rst   (soft_rst),
    .prod_start (prod_start),
    .cons_start (cons_start)
  );

  dsc_producer #(.BEAT_W(BEAT_W)) prod_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .start    (prod_start),
    .valid    (prod_valid),
    .bytes    (prod_bytes),
    .blk_size (size_q[SZ_BLK][CNT_W-1:0]),
    .txn_size (size_q[SZ_TXN][CNT_W-1:0]),
    .txn_en   (cfg_txn_en),
    .bypass   (cfg_bypass),
    .busy     (prod_busy),
    .blk_cnt  (blk_cnt),
    .txn_cnt  (txn_cnt),
    .blk_hit  (blk_hit),
    .txn_hit  (txn_hit),
    .blk_end  (blk_end_o),
    .txn_end  (txn_end_o)
  );

  dsc_consumer #(.BEAT_W(BEAT_W)) cons_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .start     (cons_start),
    .valid     (cons_valid),
    .bytes     (cons_bytes),
    .pipe_size (size_q[SZ_CPIPE][CNT_W-1:0]),
    .endless   (cfg.endless),
    .busy      (cons_busy),
    .done_hit  (cons_done)
  );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
  import dsc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             blk_end_o,
  input logic             txn_end_o,
  input logic             prod_idle_o,
  input logic             cons_idle_o,
  input logic             bypass,
  input logic             txn_en,
  input logic             prod_busy,
  input logic             blk_hit,
  input logic             txn_hit,
  input logic [CNT_W-1:0] blk_cnt,
  input logic [CNT_W-1:0] txn_cnt,
  input logic             soft_rst,
  input logic             prod_start
);

  // R5
  blk_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end_o |-> $past(blk_hit));

  // R5
  blk_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end_o |-> blk_cnt == '0);

  // R6
  txn_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end_o |-> $past(txn_en) && $past(txn_hit));

  // R6
  txn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end_o |-> !prod_busy && blk_cnt == '0 && txn_cnt == '0);

  // R9
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bypass) |-> !blk_end_o && !txn_end_o);

  // R9
  bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> prod_idle_o && cons_idle_o);

  // R3
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prod_busy) |-> $past(prod_start));

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> !prod_busy && blk_cnt == '0 && txn_cnt == '0 && !bypass);

endmodule

bind dma_sideband_ctrl dsc_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .blk_end_o   (blk_end_o),
  .txn_end_o   (txn_end_o),
  .prod_idle_o (prod_idle_o),
  .cons_idle_o (cons_idle_o),
  .bypass      (cfg_bypass),
  .txn_en      (cfg_txn_en),
  .prod_busy   (prod_busy),
  .blk_hit     (blk_hit),
  .txn_hit     (txn_hit),
  .blk_cnt     (blk_cnt),
  .txn_cnt     (txn_cnt),
  .soft_rst    (soft_rst),
  .prod_start  (prod_start)
);

// File: tb/dma_sideband_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_sideband_ctrl_tb_top;

  localparam int AW     = 8;
  localparam int BEAT_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              prod_valid = 1'b0;
  logic [BEAT_W-1:0] prod_bytes = '0;
  logic              cons_valid = 1'b0;
  logic [BEAT_W-1:0] cons_bytes = '0;
  logic              blk_end_o;
  logic              txn_end_o;
  logic              prod_idle_o;
  logic              cons_idle_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_sideband_ctrl #(.AW(AW), .BEAT_W(BEAT_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .prod_valid  (prod_valid),
    .prod_bytes  (prod_bytes),
    .cons_valid  (cons_valid),
    .cons_bytes  (cons_bytes),
    .blk_end_o   (blk_end_o),
    .txn_end_o   (txn_end_o),
    .prod_idle_o (prod_idle_o),
    .cons_idle_o (cons_idle_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pbeat(input int n, output logic b, output logic t);
    @(negedge clk);
    prod_valid = 1'b1; prod_bytes = BEAT_W'(n);
    @(negedge clk);
    prod_valid = 1'b0;
    b = blk_end_o; t = txn_end_o;
  endtask

  task automatic cbeat(input int n);
    @(negedge clk);
    cons_valid = 1'b1; cons_bytes = BEAT_W'(n);
    @(negedge clk);
    cons_valid = 1'b0;
  endtask

  task automatic soft_reset();
    wr(8'h08, 32'h1);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(8'h04, d); check("R1", "status", d, 32'h0001_0001);
    rd(8'h00, d); check("R1", "config", d, 32'h0);
    check("R1", "markers", {30'd0, blk_end_o, txn_end_o}, 32'h0);
  endtask

  task automatic t_reg_masks();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2", "config mask", d, 32'h0007_001F);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); check("R2", "pipe id mask", d, 32'h001F_001F);
    wr(8'h14, 32'hDEAD_1000); rd(8'h14, d); check("R2", "prod pipe size", d, 32'hDEAD_1000);
    wr(8'h28, 32'h1234_5678); rd(8'h28, d); check("R2", "txn size", d, 32'h1234_5678);
    soft_reset();
  endtask

  task automatic t_idle_beats();
    logic b, t; logic [31:0] d;
    wr(8'h24, 32'd4); wr(8'h28, 32'd4); wr(8'h00, 32'h11);
    pbeat(4, b, t);
    check("R12", "pulses while idle", {30'd0, b, t}, 32'h0);
    rd(8'h20, d); check("R12", "tracker while idle", d, 32'h0);
    soft_reset();
  endtask

  task automatic t_producer_aligned();
    logic b, t; logic [31:0] d;
    wr(8'h24, 32'd8); wr(8'h28, 32'd24); wr(8'h00, 32'h11);
    wr(8'h0C, 32'h1);
    rd(8'h04, d); check("R3", "producer busy", d, 32'h0001_0000);
    rd(8'h00, d); check("R3", "config untouched by start", d, 32'h11);
    pbeat(4, b, t);
    check("R5", "no marker mid block", {30'd0, b, t}, 32'h0);
    rd(8'h20, d); check("R4", "tracker after 4", d, 32'h0004_0004);
    pbeat(4, b, t);
    check("R5", "block end at 8", {30'd0, b, t}, 32'h2);
    rd(8'h20, d); check("R5", "block counter wrap", d, 32'h0008_0000);
    pbeat(4, b, t); pbeat(4, b, t);
    check("R5", "block end at 16", {30'd0, b, t}, 32'h2);
    pbeat(4, b, t);
    rd(8'h20, d); check("R4", "tracker after 20", d, 32'h0014_0004);
    pbeat(4, b, t);
    check("R6", "both markers same cycle", {30'd0, b, t}, 32'h3);
    rd(8'h20, d); check("R6", "counters cleared", d, 32'h0);
    rd(8'h04, d); check("R6", "producer idle", d, 32'h0001_0001);
    @(negedge clk);
    check("R6", "markers single cycle", {30'd0, blk_end_o, txn_end_o}, 32'h0);
  endtask

  task automatic t_producer_partial();
    logic b, t; logic [31:0] d;
    wr(8'h24, 32'd8); wr(8'h28, 32'd20); wr(8'h00, 32'h11);
    wr(8'h0C, 32'h1);
    pbeat(8, b, t); pbeat(8, b, t);
    pbeat(4, b, t);
    check("R6", "txn end mid block", {30'd0, b, t}, 32'h1);
    rd(8'h20, d); check("R6", "counters cleared mid block", d, 32'h0);
    soft_reset();
  endtask

  task automatic t_no_txn_end();
    logic b, t; logic [31:0] d;
    wr(8'h24, 32'd8); wr(8'h28, 32'd8); wr(8'h00, 32'h01);
    wr(8'h0C, 32'h1);
    pbeat(8, b, t);
    check("R7", "block only marker", {30'd0, b, t}, 32'h2);
    pbeat(8, b, t);
    check("R7", "still no txn end", {31'd0, t}, 32'h0);
    rd(8'h20, d); check("R7", "txn counter keeps counting", d, 32'h0010_0000);
    rd(8'h04, d); check("R7", "producer still busy", d, 32'h0001_0000);
    soft_reset();
  endtask

  task automatic t_consumer();
    logic [31:0] d;
    wr(8'h18, 32'd12);
    wr(8'h10, 32'h1);
    rd(8'h04, d); check("R8", "consumer busy", d, 32'h0000_0001);
    cbeat(4); cbeat(4);
    rd(8'h04, d); check("R8", "consumer busy at 8", d, 32'h0000_0001);
    cbeat(4);
    rd(8'h04, d); check("R8", "consumer idle at 12", d, 32'h0001_0001);
    wr(8'h00, 32'h0004_0000);
    wr(8'h10, 32'h1);
    cbeat(4); cbeat(4); cbeat(4); cbeat(4);
    rd(8'h04, d); check("R8", "endless consumer stays busy", d, 32'h0000_0001);
    soft_reset();
  endtask

  task automatic t_bypass();
    logic b, t; logic [31:0] d;
    logic [1:0] seen = 2'b00;
    wr(8'h24, 32'd4); wr(8'h28, 32'd8); wr(8'h00, 32'h0001_0011);
    wr(8'h0C, 32'h1); wr(8'h10, 32'h1);
    rd(8'h04, d); check("R9", "status idle in bypass", d, 32'h0001_0001);
    pbeat(4, b, t); seen |= {b, t};
    pbeat(4, b, t); seen |= {b, t};
    check("R9", "no markers in bypass", {30'd0, seen}, 32'h0);
    check("R9", "idle pins in bypass", {30'd0, prod_idle_o, cons_idle_o}, 32'h3);
    soft_reset();
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(8'h00, 32'h0004_001F); wr(8'h1C, 32'h0003_0007); wr(8'h24, 32'd16);
    wr(8'h0C, 32'h1); wr(8'h10, 32'h1);
    soft_reset();
    rd(8'h00, d); check("R10", "config cleared", d, 32'h0);
    rd(8'h1C, d); check("R10", "pipe id cleared", d, 32'h0);
    rd(8'h24, d); check("R10", "block size cleared", d, 32'h0);
    rd(8'h04, d); check("R10", "both idle", d, 32'h0001_0001);
  endtask

  task automatic t_undefined();
    logic [31:0] d;
    wr(8'h00, 32'h05);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h40, d); check("R11", "read 0x40", d, 32'h0);
    rd(8'h2C, d); check("R11", "read 0x2C", d, 32'h0);
    rd(8'h00, d); check("R11", "config unchanged", d, 32'h05);
    rd(8'h04, d); check("R11", "status unchanged", d, 32'h0001_0001);
    soft_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reg_masks();
    t_idle_beats();
    t_producer_aligned();
    t_producer_partial();
    t_no_txn_end();
    t_consumer();
    t_bypass();
    t_soft_reset();
    t_undefined();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule